// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two component predictors. The global component uses a shift register of recent outcomes, shared by every branch, to index a table of 2-bit counters. The local component keeps a 10-bit outcome history for each branch, selected by a hash of the PC. That history indexes a table of 3-bit counters. A chooser table of 2-bit counters, indexed by a PC hash, decides for each branch which component to trust.

The fetch side presents a guess PC. In the same cycle it receives the final direction, both component directions, the chooser's pick, and the two history values that were used. It keeps these as a snapshot. When the back end resolves the branch, it returns the PC, the real outcome and that snapshot on the update port. The block then trains all three structures and both histories. After reset, a controller clears the tables one index per cycle and raises `ready_o` when the clear is finished.

Top module: `tournament_predictor`

## Requirements
- R1: During reset `ready_o` is low. It rises after exactly 4096 rising edges following reset release, and it then stays high. At that point every counter is weakly not-taken (2-bit = 1, 3-bit = 3), every history is zero, and every chooser entry is 1 (weakly prefer global).
- R2: The chooser index is the XOR of the 12-bit slices of the PC, taken from bit 0 upward with the last slice zero-padded. A chooser value of 2 or more sets `pred_use_local_o`, and `pred_taken_o` then equals the local direction; otherwise it equals the global direction.
- R3: `pred_global_o` is set when the 2-bit global counter indexed by the global history register is 2 or more. `pred_ghist_o` shows that register.
- R4: The local history index is the XOR of the 10-bit slices of the PC, formed the same way as the chooser index. `pred_lhist_o` shows the selected history. `pred_local_o` is set when the 3-bit counter indexed by that history is 4 or more.
- R5: An accepted update moves the global counter at index `upd_ghist_i` up on taken and down on not-taken, saturating at 0 and 3.
- R6: An accepted update moves the local counter at index `upd_lhist_i` up or down in the same way, saturating at 0 and 7.
- R7: An accepted update shifts the outcome into bit 0 of the stored local history entry of `upd_pc_i`, dropping bit 9.
- R8: Each accepted update shifts the outcome into bit 0 of the global history register, dropping bit 11. Without an update the register holds its value.
- R9: The chooser entry of `upd_pc_i` is trained only when `upd_global_i` differs from `upd_local_i`. It moves up when the local guess matched the outcome and down otherwise, saturating at 0 and 3.
- R10: Updates presented while `ready_o` is low are ignored. An update accepted at an edge is visible to a prediction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_o | output | 1 | Tables cleared; predictions and updates valid |
| pred_pc_i | input | 32 | Guess PC to predict |
| pred_taken_o | output | 1 | Final direction |
| pred_global_o | output | 1 | Global component direction |
| pred_local_o | output | 1 | Local component direction |
| pred_use_local_o | output | 1 | Chooser selected the local component |
| pred_ghist_o | output | 12 | Global history used (snapshot) |
| pred_lhist_o | output | 10 | Local history used (snapshot) |
| upd_valid_i | input | 1 | Resolved-branch update strobe |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome |
| upd_ghist_i | input | 12 | Snapshot global history |
| upd_lhist_i | input | 10 | Snapshot local history |
| upd_global_i | input | 1 | Snapshot global direction |
| upd_local_i | input | 1 | Snapshot local direction |

## Verification
Prediction outputs are combinational from the guess PC and the current tables, so they are due in the same cycle. The bench samples them just after the falling edge, once the PC has settled. An update changes the tables at the next rising edge, so the bench applies it to its reference model immediately after that edge, and the following cycle's prediction is compared against the updated model. `ready_o` is due 4096 edges after reset release, and the bench counts edges to check that figure exactly.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } tp_state_e;

    // Saturating up/down step for a counter of up to 4 bits.
    function automatic logic [3:0] sat_step(input logic [3:0] v,
                                            input logic       up,
                                            input logic [3:0] maxv);
        logic [3:0] r;
        if (up) r = (v == maxv) ? v : v + 4'd1;
        else    r = (v == 4'd0) ? v : v - 4'd1;
        return r;
    endfunction

endpackage

// File: rtl/tp_table.sv
module tp_table #(
    parameter int DEPTH = 1024,
    parameter int W     = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] rd0_idx,
    output logic [W-1:0]  rd0_data,
    input  logic [AW-1:0] rd1_idx,
    output logic [W-1:0]  rd1_data,
    input  logic          we,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_data;
    end

    assign rd0_data = mem[rd0_idx];
    assign rd1_data = mem[rd1_idx];
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
    import tp_pkg::*;
#(
    parameter int CYCLES = 4096,
    localparam int CW    = $clog2(CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    output logic          clr_en,
    output logic [CW-1:0] clr_idx
);
    tp_state_e state_q, state_d;
    logic [CW-1:0] idx_q, idx_d;
    logic last;

    assign last = (idx_q == CW'(CYCLES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        ready   = 1'b0;
        clr_en  = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                clr_en = 1'b1;
                idx_d  = idx_q + CW'(1);
                if (last) state_d = ST_RUN;
            end
            ST_RUN: begin
                ready = 1'b1;
            end
        endcase
    end

    assign clr_idx = idx_q;
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int CH_ENTRIES = 4096,
    parameter int GH_W       = 12,
    parameter int LH_ENTRIES = 1024,
    parameter int LH_W       = 10,
    parameter int GCW        = 2,
    parameter int LCW        = 3,
    parameter int CHW        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            ready_o,
    input  logic [PC_W-1:0] pred_pc_i,
    output logic            pred_taken_o,
    output logic            pred_global_o,
    output logic            pred_local_o,
    output logic            pred_use_local_o,
    output logic [GH_W-1:0] pred_ghist_o,
    output logic [LH_W-1:0] pred_lhist_o,
    input  logic            upd_valid_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i,
    input  logic [GH_W-1:0] upd_ghist_i,
    input  logic [LH_W-1:0] upd_lhist_i,
    input  logic            upd_global_i,
    input  logic            upd_local_i
);
    localparam int CH_AW   = $clog2(CH_ENTRIES);
    localparam int LH_AW   = $clog2(LH_ENTRIES);
    localparam int G_DEPTH = 1 << GH_W;
    localparam int L_DEPTH = 1 << LH_W;
    localparam int INIT_N0 = (CH_ENTRIES > G_DEPTH) ? CH_ENTRIES : G_DEPTH;
    localparam int INIT_N1 = (LH_ENTRIES > L_DEPTH) ? LH_ENTRIES : L_DEPTH;
    localparam int INIT_N  = (INIT_N0 > INIT_N1) ? INIT_N0 : INIT_N1;
    localparam int IW      = $clog2(INIT_N);
    localparam logic [GCW-1:0] G_WEAK  = GCW'((1 << (GCW - 1)) - 1);
    localparam logic [LCW-1:0] L_WEAK  = LCW'((1 << (LCW - 1)) - 1);
    localparam logic [CHW-1:0] CH_WEAK = CHW'((1 << (CHW - 1)) - 1);

    function automatic logic [CH_AW-1:0] fold_ch(input logic [PC_W-1:0] pc);
        logic [CH_AW-1:0] r = '0;
        for (int i = 0; i < PC_W; i += CH_AW) r ^= CH_AW'(pc >> i);
        return r;
    endfunction

    function automatic logic [LH_AW-1:0] fold_lh(input logic [PC_W-1:0] pc);
        logic [LH_AW-1:0] r = '0;
        for (int i = 0; i < PC_W; i += LH_AW) r ^= LH_AW'(pc >> i);
        return r;
    endfunction

    // ---------------- controller ----------------
    logic          clr_en;
    logic [IW-1:0] clr_idx;
    logic          fire;

    tp_ctrl #(.CYCLES(INIT_N)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready  (ready_o),
        .clr_en (clr_en),
        .clr_idx(clr_idx)
    );

    assign fire = ready_o && upd_valid_i;

    // ---------------- global history register ----------------
    logic [GH_W-1:0] ghr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ghr_q <= '0;
        else if (fire) ghr_q <= {ghr_q[GH_W-2:0], upd_taken_i};
    end

    // ---------------- indices ----------------
    logic [CH_AW-1:0] p_ch_idx, u_ch_idx;
    logic [LH_AW-1:0] p_lh_idx, u_lh_idx;
    assign p_ch_idx = fold_ch(pred_pc_i);
    assign u_ch_idx = fold_ch(upd_pc_i);
    assign p_lh_idx = fold_lh(pred_pc_i);
    assign u_lh_idx = fold_lh(upd_pc_i);

    // ---------------- chooser ----------------
    logic [CHW-1:0]   ch_p, ch_u, ch_wd;
    logic             ch_we;
    logic [CH_AW-1:0] ch_wi;
    always_comb begin
        ch_we = 1'b0;
        ch_wi = u_ch_idx;
        ch_wd = ch_u;
        if (clr_en) begin
            ch_we = (32'(clr_idx) < CH_ENTRIES);
            ch_wi = CH_AW'(clr_idx);
            ch_wd = CH_WEAK;
        end else if (fire && (upd_global_i != upd_local_i)) begin
            ch_we = 1'b1;
            ch_wd = CHW'(sat_step(4'(ch_u), upd_local_i == upd_taken_i,
                                  4'((1 << CHW) - 1)));
        end
    end

    tp_table #(.DEPTH(CH_ENTRIES), .W(CHW)) u_chooser (
        .clk(clk), .rd0_idx(p_ch_idx), .rd0_data(ch_p),
        .rd1_idx(u_ch_idx), .rd1_data(ch_u),
        .we(ch_we), .wr_idx(ch_wi), .wr_data(ch_wd)
    );

    // ---------------- global counters ----------------
    logic [GCW-1:0]  g_p, g_u, g_wd;
    logic            g_we;
    logic [GH_W-1:0] g_wi;
    always_comb begin
        g_we = 1'b0;
        g_wi = upd_ghist_i;
        g_wd = g_u;
        if (clr_en) begin
            g_we = (32'(clr_idx) < G_DEPTH);
            g_wi = GH_W'(clr_idx);
            g_wd = G_WEAK;
        end else if (fire) begin
            g_we = 1'b1;
            g_wd = GCW'(sat_step(4'(g_u), upd_taken_i, 4'((1 << GCW) - 1)));
        end
    end

    tp_table #(.DEPTH(G_DEPTH), .W(GCW)) u_gctr (
        .clk(clk), .rd0_idx(ghr_q), .rd0_data(g_p),
        .rd1_idx(upd_ghist_i), .rd1_data(g_u),
        .we(g_we), .wr_idx(g_wi), .wr_data(g_wd)
    );

    // ---------------- local histories ----------------
    logic [LH_W-1:0]  lh_p, lh_u, lh_wd;
    logic             lh_we;
    logic [LH_AW-1:0] lh_wi;
    always_comb begin
        lh_we = 1'b0;
        lh_wi = u_lh_idx;
        lh_wd = lh_u;
        if (clr_en) begin
            lh_we = (32'(clr_idx) < LH_ENTRIES);
            lh_wi = LH_AW'(clr_idx);
            lh_wd = '0;
        end else if (fire) begin
            lh_we = 1'b1;
            lh_wd = {lh_u[LH_W-2:0], upd_taken_i};
        end
    end

    tp_table #(.DEPTH(LH_ENTRIES), .W(LH_W)) u_lhist (
        .clk(clk), .rd0_idx(p_lh_idx), .rd0_data(lh_p),
        .rd1_idx(u_lh_idx), .rd1_data(lh_u),
        .we(lh_we), .wr_idx(lh_wi), .wr_data(lh_wd)
    );

    // ---------------- local counters ----------------
    logic [LCW-1:0]  l_p, l_u, l_wd;
    logic            l_we;
    logic [LH_W-1:0] l_wi;
    always_comb begin
        l_we = 1'b0;
        l_wi = upd_lhist_i;
        l_wd = l_u;
        if (clr_en) begin
            l_we = (32'(clr_idx) < L_DEPTH);
            l_wi = LH_W'(clr_idx);
            l_wd = L_WEAK;
        end else if (fire) begin
            l_we = 1'b1;
            l_wd = LCW'(sat_step(4'(l_u), upd_taken_i, 4'((1 << LCW) - 1)));
        end
    end

    tp_table #(.DEPTH(L_DEPTH), .W(LCW)) u_lctr (
        .clk(clk), .rd0_idx(lh_p), .rd0_data(l_p),
        .rd1_idx(upd_lhist_i), .rd1_data(l_u),
        .we(l_we), .wr_idx(l_wi), .wr_data(l_wd)
    );

    // ---------------- prediction outputs ----------------
    always_comb begin
        pred_global_o    = g_p[GCW-1];
        pred_local_o     = l_p[LCW-1];
        pred_use_local_o = ch_p[CHW-1];
        pred_taken_o     = pred_use_local_o ? pred_local_o : pred_global_o;
        pred_ghist_o     = ghr_q;
        pred_lhist_o     = lh_p;
    end
endmodule

// File: rtl/tournament_predictor_chk.sv
module tournament_predictor_chk #(
    parameter int GH_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready_o,
    input logic            pred_taken_o,
    input logic            pred_global_o,
    input logic            pred_local_o,
    input logic            pred_use_local_o,
    input logic [GH_W-1:0] pred_ghist_o,
    input logic            upd_valid_i,
    input logic            upd_taken_i
);
    // R1: once ready, stays ready
    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R2: final direction follows the chosen component
    a_r2_final_select: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (pred_taken_o == (pred_use_local_o ? pred_local_o : pred_global_o)));

    // R8: accepted update shifts the outcome into the history
    a_r8_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && upd_valid_i) |=>
            (pred_ghist_o == {$past(pred_ghist_o[GH_W-2:0]), $past(upd_taken_i)}));

    // R8: history holds without an update
    a_r8_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !upd_valid_i) |=> $stable(pred_ghist_o));

    // R10: nothing moves the history while clearing
    a_r10_ignore_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (pred_ghist_o == '0));
endmodule

bind tournament_predictor tournament_predictor_chk #(.GH_W(GH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready_o(ready_o),
    .pred_taken_o(pred_taken_o), .pred_global_o(pred_global_o),
    .pred_local_o(pred_local_o), .pred_use_local_o(pred_use_local_o),
    .pred_ghist_o(pred_ghist_o), .upd_valid_i(upd_valid_i),
    .upd_taken_i(upd_taken_i)
);

// File: tb/tournament_predictor_bench.sv
`timescale 1ns/1ps
module tournament_predictor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready_o;
    logic [31:0] pred_pc_i = '0;
    logic        pred_taken_o, pred_global_o, pred_local_o, pred_use_local_o;
    logic [11:0] pred_ghist_o;
    logic [9:0]  pred_lhist_o;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic        upd_taken_i = 1'b0;
    logic [11:0] upd_ghist_i = '0;
    logic [9:0]  upd_lhist_i = '0;
    logic        upd_global_i = 1'b0;
    logic        upd_local_i = 1'b0;

    always #5 clk = ~clk;

    tournament_predictor u_tournament_predictor (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    int m_ch [4096];
    int m_g  [4096];
    int m_l  [1024];
    int m_lh [1024];
    int m_ghr;

    function automatic int fold(input logic [31:0] pc, input int aw);
        int r = 0;
        for (int i = 0; i < 32; i += aw) r ^= int'((pc >> i) & ((1 << aw) - 1));
        return r;
    endfunction

    function automatic int sat(input int v, input bit up, input int mx);
        if (up) return (v == mx) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare outputs for the PC currently driven
    task automatic check_pred();
        int lh, eg, el, eu;
        lh = m_lh[fold(pred_pc_i, 10)];
        eg = (m_g[m_ghr] >= 2) ? 1 : 0;
        el = (m_l[lh] >= 4) ? 1 : 0;
        eu = (m_ch[fold(pred_pc_i, 12)] >= 2) ? 1 : 0;
        chk("R3 ghist",  int'(pred_ghist_o), m_ghr);
        chk("R3 global", int'(pred_global_o), eg);
        chk("R4 lhist",  int'(pred_lhist_o), lh);
        chk("R4 local",  int'(pred_local_o), el);
        chk("R2 choose", int'(pred_use_local_o), eu);
        chk("R2 final",  int'(pred_taken_o), eu ? el : eg);
    endtask

    // R5 R6 R7 R8 R9 model update
    task automatic model_upd();
        int ci, li;
        ci = fold(upd_pc_i, 12);
        li = fold(upd_pc_i, 10);
        m_g[upd_ghist_i] = sat(m_g[upd_ghist_i], upd_taken_i, 3);
        m_l[upd_lhist_i] = sat(m_l[upd_lhist_i], upd_taken_i, 7);
        m_lh[li] = ((m_lh[li] << 1) | int'(upd_taken_i)) & 1023;
        m_ghr = ((m_ghr << 1) | int'(upd_taken_i)) & 4095;
        if (upd_global_i != upd_local_i)
            m_ch[ci] = sat(m_ch[ci], upd_local_i == upd_taken_i, 3);
    endtask

    // one cycle: predict, check, optionally update from snapshot
    task automatic step(input logic [31:0] pc, input bit v, input bit t,
                        input bit corrupt);
        @(negedge clk);
        pred_pc_i = pc;
        upd_valid_i = 1'b0;
        #1;
        check_pred();
        upd_valid_i  = v;
        upd_pc_i     = pc;
        upd_taken_i  = t;
        upd_ghist_i  = corrupt ? 12'($urandom) : pred_ghist_o;
        upd_lhist_i  = corrupt ? 10'($urandom) : pred_lhist_o;
        upd_global_i = corrupt ? 1'($urandom) : pred_global_o;
        upd_local_i  = corrupt ? 1'($urandom) : pred_local_o;
        @(posedge clk);
        if (v) model_upd();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int edges;
        logic [31:0] pcs [8];
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4096; i++) begin m_ch[i] = 1; m_g[i] = 1; end
        for (int i = 0; i < 1024; i++) begin m_l[i] = 3; m_lh[i] = 0; end
        m_ghr = 0;

        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", int'(ready_o), 0);
        rst_n = 1'b1;
        // R10: updates during the clear must be ignored
        upd_valid_i = 1'b1;
        upd_taken_i = 1'b1;
        upd_pc_i = 32'h40;
        upd_ghist_i = 12'h0;
        upd_lhist_i = 10'h0;
        upd_global_i = 1'b0;
        upd_local_i = 1'b1;
        edges = 0;
        while (!ready_o && edges < 5000) begin
            @(posedge clk);
            edges++;
            #1;
        end
        chk("R1 clear length", edges, 4096);
        upd_valid_i = 1'b0;
        @(negedge clk);
        chk("R10 ghist after ignored updates", int'(pred_ghist_o), 0);

        // R1 reset values at several PCs
        step(32'h0000_0040, 0, 0, 0);
        step(32'hdead_beec, 0, 0, 0);
        chk("R1 weak not-taken", int'(pred_taken_o), 0);

        // directed: saturate global counter and loop pattern for one branch
        for (int i = 0; i < 6; i++) step(32'h0000_1000, 1, 1, 0);
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 4; k++) step(32'h0000_2000, 1, 1, 0);
            step(32'h0000_2000, 1, 0, 0);
        end
        // directed: not-taken saturation at zero
        for (int i = 0; i < 12; i++) step(32'h0000_3004, 1, 0, 0);

        // random mix over a small aliasing PC set
        pcs[0] = 32'h0000_1000; pcs[1] = 32'h0000_1004;
        pcs[2] = 32'h0100_1000; pcs[3] = 32'h0000_2000;
        pcs[4] = 32'h8000_0010; pcs[5] = 32'h0000_7ffc;
        pcs[6] = 32'h0040_0400; pcs[7] = 32'h1234_5678;
        for (int n = 0; n < 3000; n++) begin
            int sel;
            bit t;
            sel = int'($urandom_range(0, 7));
            t = (sel < 3) ? ($urandom_range(0, 9) < 8) : bit'($urandom);
            step(pcs[sel], $urandom_range(0, 9) < 8, t,
                 $urandom_range(0, 9) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule